// File: doc/BRIEF.md
# Serial Audio Port Transmit/Receive FIFO Pair

This block sits between a simple register bus and the shift logic of a synchronous serial audio port. It holds one transmit FIFO and one receive FIFO, each 16 entries of 32 bits, and one entry holds one audio sample. Both FIFOs sit behind a single data word address. The bus direction picks the FIFO: a write pushes a sample toward the serializer, and a read pops a sample that the deserializer collected.

The sample width is programmable. A 4-bit size field and an extension bit together give a width of 1 to 32 bits. Transmit samples leave the block with every bit above that width forced to zero. Received samples are stored with those bits cleared.

Each FIFO has a 4-bit threshold. The level comparison against it sets a service flag. Each flag drives a shared interrupt line and its own DMA request line, and each path has its own enable. A status word reports the levels, the not-full and not-empty flags, the service flags and two sticky overflow flags.

Top module: `sport_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty, the control word reads 0, `tx_valid_o`, `irq_o`, `dma_tx_req_o` and `dma_rx_req_o` are low, and the status word reads 0x0005_0000.
- R2: A bus write to word address 2 pushes `bus_wdata_i` into the transmit FIFO. `tx_data_o` shows the oldest entry while `tx_valid_o` is high, and `tx_pop_i` removes it in first-in first-out order.
- R3: A bus read of word address 2 returns the oldest receive entry in the same cycle and pops it at the clock edge. A read of an empty receive FIFO returns 0 and changes nothing.
- R4: The sample width is {ext, size}+1 bits, with size in control bits [3:0] and ext in bit 4. On `tx_data_o`, every bit at or above the sample width is 0.
- R5: A push on `rx_push_i` stores `rx_data_i` with every bit at or above the sample width cleared.
- R6: A bus write to a full transmit FIFO (16 entries) is dropped and sets sticky status bit 20. Writing 1 to status bit 20 at word address 1 clears it.
- R7: A receive push into a full FIFO is dropped and sets sticky status bit 21. Writing 1 to status bit 21 clears it.
- R8: Status bit 19 (receive service) is 1 when receive level >= control[11:8]+1. Status bit 18 (transmit service) is 1 when transmit level <= control[15:12].
- R9: `irq_o` = (bit19 & control[16]) | (bit18 & control[17]). `dma_rx_req_o` = bit19 & control[18]. `dma_tx_req_o` = bit18 & control[19].
- R10: Status [7:0] is the transmit level, [15:8] the receive level, bit 16 transmit not full, bit 17 receive not empty.
- R11: Control bits [3:0], 4 and [19:8] written at word address 0 read back unchanged. All other control bits read 0, and word address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address: 0 control, 1 status, 2 data |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| tx_pop_i | input | 1 | Serializer takes the head sample |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_data_o | output | 32 | Head transmit sample, masked to the width |
| rx_push_i | input | 1 | Deserializer delivers a sample |
| rx_data_i | input | 32 | Received sample |
| irq_o | output | 1 | Interrupt request |
| dma_tx_req_o | output | 1 | Transmit refill DMA request |
| dma_rx_req_o | output | 1 | Receive drain DMA request |

## Verification
Every state change lands on the clock edge that closes an access. Read data is combinational from the receive head, so it is due within the access cycle itself. Levels, status, `tx_data_o` and the request lines are due in the cycle that follows the edge. The bench drives stimulus on the falling edge and samples either 1 ns after driving, for read data, or at the next falling edge, for everything else, so each value is read one register stage after its cause. Transmit and receive samples are compared in order against queues that the driver tasks fill with values masked by the bench's own copy of the sample width.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;

  localparam int unsigned ST_TX_NFULL  = 16;
  localparam int unsigned ST_RX_NEMPTY = 17;
  localparam int unsigned ST_TX_REQ    = 18;
  localparam int unsigned ST_RX_REQ    = 19;
  localparam int unsigned ST_TX_OVR    = 20;
  localparam int unsigned ST_RX_OVR    = 21;

  typedef struct packed {
    logic       tx_dma_en;
    logic       rx_dma_en;
    logic       tx_irq_en;
    logic       rx_irq_en;
    logic [3:0] tx_thr;
    logic [3:0] rx_thr;
    logic [2:0] pad;
    logic       ext;
    logic [3:0] size;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // width = {ext,size}+1 -> 1..32 bits
  function automatic logic [DATA_W-1:0] width_mask(logic ext, logic [3:0] size);
    logic [5:0] w;
    w = {1'b0, ext, size} + 6'd1;
    if (w >= 6'd32) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/sfp_regs.sv
module sfp_regs
  import sfp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              status_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_ovr_set_i,
  input  logic              rx_ovr_set_i,
  output ctrl_t             ctrl_o,
  output logic              tx_ovr_o,
  output logic              rx_ovr_o
);
  ctrl_t ctrl_q;
  logic  tx_ovr_q, rx_ovr_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d     = ctrl_t'(wdata_i[CTRL_W-1:0]);
    ctrl_d.pad = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      tx_ovr_q <= 1'b0;
      rx_ovr_q <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_d;
      // a new overflow wins over a clear in the same cycle
      if (tx_ovr_set_i)                               tx_ovr_q <= 1'b1;
      else if (status_we_i && wdata_i[ST_TX_OVR])     tx_ovr_q <= 1'b0;
      if (rx_ovr_set_i)                               rx_ovr_q <= 1'b1;
      else if (status_we_i && wdata_i[ST_RX_OVR])     rx_ovr_q <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign tx_ovr_o = tx_ovr_q;
  assign rx_ovr_o = rx_ovr_q;
endmodule

// File: rtl/sport_fifo_pair.sv
module sport_fifo_pair
  import sfp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              tx_pop_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              irq_o,
  output logic              dma_tx_req_o,
  output logic              dma_rx_req_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] mask;
  logic              wr_data, rd_data;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [LW-1:0]     tx_level, rx_level;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovr, rx_ovr;
  logic              tx_req, rx_req;
  logic [DATA_W-1:0] status;

  assign mask    = width_mask(ctrl.ext, ctrl.size);
  assign wr_data = bus_sel_i & bus_we_i  & (bus_addr_i == ADDR_DATA);
  assign rd_data = bus_sel_i & ~bus_we_i & (bus_addr_i == ADDR_DATA);

  sfp_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (bus_sel_i & bus_we_i & (bus_addr_i == ADDR_CTRL)),
    .status_we_i  (bus_sel_i & bus_we_i & (bus_addr_i == ADDR_STATUS)),
    .wdata_i      (bus_wdata_i),
    .tx_ovr_set_i (wr_data & tx_full),
    .rx_ovr_set_i (rx_push_i & rx_full),
    .ctrl_o       (ctrl),
    .tx_ovr_o     (tx_ovr),
    .rx_ovr_o     (rx_ovr)
  );

  sfp_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .pop_i   (tx_pop_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (tx_head),
    .level_o (tx_level),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  sfp_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push_i),
    .pop_i   (rd_data),
    .wdata_i (rx_data_i & mask),
    .rdata_o (rx_head),
    .level_o (rx_level),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  // tx masked at the output so a width change applies to queued samples too
  assign tx_valid_o = ~tx_empty;
  assign tx_data_o  = tx_empty ? '0 : (tx_head & mask);

  assign rx_req = (rx_level >= (LW'(ctrl.rx_thr) + LW'(1)));
  assign tx_req = (tx_level <= LW'(ctrl.tx_thr));

  assign irq_o        = (rx_req & ctrl.rx_irq_en) | (tx_req & ctrl.tx_irq_en);
  assign dma_rx_req_o = rx_req & ctrl.rx_dma_en;
  assign dma_tx_req_o = tx_req & ctrl.tx_dma_en;

  always_comb begin
    status               = '0;
    status[LW-1:0]       = tx_level;
    status[8 +: LW]      = rx_level;
    status[ST_TX_NFULL]  = ~tx_full;
    status[ST_RX_NEMPTY] = ~rx_empty;
    status[ST_TX_REQ]    = tx_req;
    status[ST_RX_REQ]    = rx_req;
    status[ST_TX_OVR]    = tx_ovr;
    status[ST_RX_OVR]    = rx_ovr;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (bus_addr_i)
        ADDR_CTRL:   bus_rdata_o = DATA_W'(ctrl);
        ADDR_STATUS: bus_rdata_o = status;
        ADDR_DATA:   bus_rdata_o = rx_empty ? '0 : rx_head;
        default:     bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sport_fifo_pair_chk.sv
module sport_fifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_sel_i,
  input logic          bus_we_i,
  input logic [1:0]    bus_addr_i,
  input logic [31:0]   bus_rdata_o,
  input logic          tx_pop_i,
  input logic          rx_push_i,
  input logic          irq_o,
  input logic          rx_irq_en,
  input logic          tx_irq_en,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_ovr,
  input logic          rx_ovr
);
  logic wr_d, rd_d;
  assign wr_d = bus_sel_i & bus_we_i & (bus_addr_i == 2'd2);
  assign rd_d = bus_sel_i & ~bus_we_i & (bus_addr_i == 2'd2);

  p_empty_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_d && rx_level == '0) |-> (bus_rdata_o == '0));

  p_empty_read_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_d && !rx_push_i && rx_level == '0) |=> (rx_level == '0));

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level <= LW'(DEPTH));

  p_full_write_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_d && tx_level == LW'(DEPTH)) |=> (tx_ovr && tx_level <= LW'(DEPTH)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level <= LW'(DEPTH));

  p_full_push_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_level == LW'(DEPTH)) |=> rx_ovr);

  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_irq_en && !tx_irq_en) |-> !irq_o);

  p_tx_level_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_d && !tx_pop_i) |=> $stable(tx_level));

  p_rx_level_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_d && !rx_push_i) |=> $stable(rx_level));
endmodule

bind sport_fifo_pair sport_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .tx_pop_i    (tx_pop_i),
  .rx_push_i   (rx_push_i),
  .irq_o       (irq_o),
  .rx_irq_en   (ctrl.rx_irq_en),
  .tx_irq_en   (ctrl.tx_irq_en),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .tx_ovr      (tx_ovr),
  .rx_ovr      (rx_ovr)
);

// File: tb/sport_fifo_pair_tb.sv
module sport_fifo_pair_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        tx_pop_i = 1'b0, tx_valid_o;
  logic [31:0] tx_data_o;
  logic        rx_push_i = 1'b0;
  logic [31:0] rx_data_i = '0;
  logic        irq_o, dma_tx_req_o, dma_rx_req_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] tx_q[$], rx_q[$];
  logic [31:0] cur_mask = 32'h0000_0001;

  always #4 clk_i = ~clk_i;

  sport_fifo_pair u_dut (.*);

  function automatic logic [31:0] mk_mask(logic [31:0] c);
    int w = int'({c[4], c[3:0]}) + 1;
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 0;
  endtask

  task automatic set_ctrl(logic [31:0] c);
    bus_wr(2'd0, c);
    cur_mask = mk_mask(c);
  endtask

  // driver side: schedule the expected serializer sample
  task automatic tx_send(logic [31:0] d);
    if (tx_q.size() < 16) tx_q.push_back(d & cur_mask);
    bus_wr(2'd2, d);
  endtask

  // monitor side: take the head and compare it in order
  task automatic tx_take(string req);
    @(negedge clk_i);
    chk(req, tx_data_o, tx_q.pop_front());
    tx_pop_i = 1;
    @(negedge clk_i);
    tx_pop_i = 0;
  endtask

  task automatic rx_send(logic [31:0] d);
    if (rx_q.size() < 16) rx_q.push_back(d & cur_mask);
    @(negedge clk_i);
    rx_push_i = 1; rx_data_i = d;
    @(negedge clk_i);
    rx_push_i = 0;
  endtask

  task automatic rx_take(string req);
    logic [31:0] d;
    bus_rd(2'd2, d);
    chk(req, d, rx_q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    bus_rd(2'd1, d); chk("R1 status", d, 32'h0005_0000);
    bus_rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 outputs", {28'd0, tx_valid_o, irq_o, dma_tx_req_o, dma_rx_req_o}, 32'h0);

    // R11 control readback, unused bits dropped
    set_ctrl(32'hFFF0_13E7);
    bus_rd(2'd0, d); chk("R11 ctrl", d, 32'h0000_1307);
    bus_rd(2'd3, d); chk("R11 addr3", d, 32'h0);

    // R2/R4 8-bit samples, order kept
    tx_send(32'hAABB_CC11); tx_send(32'h1234_5678); tx_send(32'hFFFF_FF80);
    bus_rd(2'd1, d);
    chk("R10 tx level", {24'd0, d[7:0]}, 32'd3);
    chk("R8 tx req off", {31'd0, d[18]}, 32'd0);
    set_ctrl(32'h0008_1307);
    @(negedge clk_i); chk("R9 dma tx off", {31'd0, dma_tx_req_o}, 32'd0);
    tx_take("R2 R4 first"); tx_take("R2 R4 second");
    chk("R9 dma tx on", {31'd0, dma_tx_req_o}, 32'd1);
    tx_take("R2 R4 third");
    chk("R2 tx empty", {31'd0, tx_valid_o}, 32'd0);

    // R4 extended widths: 20 and 32 bits
    set_ctrl(32'h13);
    tx_send(32'hDEAD_BEEF); tx_take("R4 20bit");
    set_ctrl(32'h1F);
    tx_send(32'hDEAD_BEEF); tx_take("R4 32bit");

    // R6 fill, overflow, W1C
    for (int i = 0; i < 17; i++) tx_send(32'h100 + i);
    bus_rd(2'd1, d);
    chk("R6 level full", {24'd0, d[7:0]}, 32'd16);
    chk("R10 not full", {31'd0, d[16]}, 32'd0);
    chk("R6 tx ovr set", {31'd0, d[20]}, 32'd1);
    bus_wr(2'd1, 32'h0010_0000);
    bus_rd(2'd1, d); chk("R6 tx ovr clr", {31'd0, d[20]}, 32'd0);
    for (int i = 0; i < 16; i++) tx_take("R6 drain");

    // R9 tx irq with empty fifo and threshold 0
    set_ctrl(32'h0002_001F);
    @(negedge clk_i); chk("R9 irq tx", {31'd0, irq_o}, 32'd1);

    // R5/R8/R9 receive, 12-bit width, threshold 3
    set_ctrl(32'h0005_030B);
    rx_send(32'hFFFF_FFFF); rx_send(32'h0000_ABCD); rx_send(32'h1234_5678);
    chk("R8 rx req off", {30'd0, irq_o, dma_rx_req_o}, 32'd0);
    rx_send(32'h0000_0001);
    chk("R9 rx req on", {30'd0, irq_o, dma_rx_req_o}, 32'd3);
    bus_rd(2'd1, d);
    chk("R10 rx level", {24'd0, d[15:8]}, 32'd4);
    chk("R8 rx req bit", {31'd0, d[19]}, 32'd1);
    for (int i = 0; i < 4; i++) rx_take("R5 R3 read");
    bus_rd(2'd2, d); chk("R3 empty read", d, 32'h0);
    bus_rd(2'd1, d); chk("R3 level stays", {16'd0, d[15:8], 7'd0, d[17]}, 32'd0);

    // R7 receive overflow and W1C
    set_ctrl(32'h1F);
    for (int i = 0; i < 17; i++) rx_send(32'hC000_0000 + i);
    bus_rd(2'd1, d);
    chk("R7 rx full", {24'd0, d[15:8]}, 32'd16);
    chk("R7 rx ovr set", {31'd0, d[21]}, 32'd1);
    bus_wr(2'd1, 32'h0020_0000);
    bus_rd(2'd1, d); chk("R7 rx ovr clr", {31'd0, d[21]}, 32'd0);
    for (int i = 0; i < 16; i++) rx_take("R7 drain");
    bus_rd(2'd1, d); chk("R10 rx empty", {31'd0, d[17]}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule